// File: doc/BRIEF.md
# Status Pin Mode Controller

This block drives the status output pin of a flash-style memory controller. After reset the pin reports readiness as a level: it is pulled low while the internal write engine is busy, and it is high when the engine is idle or suspended. Software can instead switch the pin into an interrupt style of signalling. In that style the pin rests high and drops low for one fixed-width pulse when an erase or a program operation completes. Each of the two kinds of completion has its own enable.

The mode is chosen with a two-write sequence on a simple byte write port. The first write is the configuration command byte. The second write carries the configuration code. The sequence is refused while the engine is busy or suspended, and it is also refused when the code is not defined. A refusal raises two error flags, which mirror bits 4 and 5 of the controller's status register. A separate clear-status command lowers those flags again. The pulse width is derived from the clock period, so the low time always lasts at least 250 ns.

Top module: `stspin_ctrl`

## Requirements
- R1: After `rst` the pin is in level mode, both error flags are 0, and the pin reflects the engine state from the first cycle after reset is released.
- R2: In level mode the pin is registered. One cycle after the inputs are sampled it is 0 when `eng_busy`=1 and `eng_susp`=0, and 1 otherwise.
- R3: A write of B8h followed by a second write carrying the code selects the mode. Code 00h returns the pin to level mode. Cycles without a write between the two writes are allowed.
- R4: Code 01h (bit 0 = erase enable) gives pulse mode. The pin rests at 1 whatever `eng_busy` is, a pulse follows `erase_done`, and `prog_done` is ignored.
- R5: Code 02h (bit 1 = program enable) gives a pulse on `prog_done` only. `erase_done` is ignored.
- R6: Code 03h gives a pulse on either completion. Both completions in the same cycle give a single pulse.
- R7: A pulse holds the pin at 0 for exactly PULSE_CYC = ceil(250 ns / clock period) cycles (25 at 100 MHz), starting one cycle after the event is sampled. A new enabled event during a pulse restarts the full width.
- R8: The configuration persists until another configuration is accepted or `rst` is asserted.
- R9: If `eng_busy` or `eng_susp` is 1 when the code is written, both error flags become 1 and the mode is unchanged.
- R10: Any code from 04h to FFh sets both error flags to 1 and leaves the mode unchanged.
- R11: Outside a configuration sequence, a write of 50h clears both flags. Other bytes written outside a sequence have no effect.
- R12: A completion reported in the same cycle as an accepted code write is judged against the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 8 | Command byte or configuration code |
| eng_busy | input | 1 | Write engine busy |
| eng_susp | input | 1 | Write engine suspended |
| erase_done | input | 1 | One-cycle erase completion event |
| prog_done | input | 1 | One-cycle program completion event |
| sts_pin | output | 1 | Registered status pin |
| err_flags | output | 2 | [0] = status bit 4, [1] = status bit 5 |

## Verification
Two pairs of events can land in the same cycle. The first pair is the code write that switches the mode and a completion event. The bench drives a code write and a completion together, once to enter level mode and once to enter erase-pulse mode. It then checks whether the pin goes low on the next cycle, judged against the configuration being loaded. The second pair is an erase completion and a program completion under code 03h. The bench checks that they produce one pulse of the nominal width. It also checks that a later event stretches the low time to the restart point.

// File: rtl/stspin_pkg.sv
package stspin_pkg;
  localparam logic [7:0] OPC_CFG = 8'hB8;
  localparam logic [7:0] OPC_CLR = 8'h50;

  typedef enum logic {
    DEC_IDLE,
    DEC_WAIT_CODE
  } dec_state_e;

  // bit 0 = erase completion enable, bit 1 = program completion enable
  typedef struct packed {
    logic prog_en;
    logic erase_en;
  } cfg_t;
endpackage

// File: rtl/stspin_cmd_dec.sv
module stspin_cmd_dec
  import stspin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eng_busy,
  input  logic       eng_susp,
  output logic       cfg_load,
  output cfg_t       cfg_new,
  output logic       err_set,
  output logic       err_clr
);
  dec_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cfg_load = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    cfg_new  = cfg_t'(wr_data[1:0]);
    if (wr_en) begin
      unique case (state_q)
        DEC_IDLE: begin
          if (wr_data == OPC_CFG) state_d = DEC_WAIT_CODE;
          else if (wr_data == OPC_CLR) err_clr = 1'b1;
        end
        DEC_WAIT_CODE: begin
          state_d = DEC_IDLE;
          if (eng_busy || eng_susp) err_set = 1'b1;
          else if (|wr_data[7:2]) err_set = 1'b1;
          else cfg_load = 1'b1;
        end
        default: state_d = DEC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= DEC_IDLE;
    else     state_q <= state_d;
  end

  // A code can only be taken after the command byte has been seen
  assert_load_after_setup_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_load |-> (state_q == DEC_WAIT_CODE));
endmodule

// File: rtl/stspin_err_reg.sv
module stspin_err_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       set,
  input  logic       clr,
  output logic [1:0] flags
);
  logic [1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)      flags_q <= 2'b00;
    else if (set) flags_q <= 2'b11;
    else if (clr) flags_q <= 2'b00;
  end

  assign flags = flags_q;

  assert_flags_rise_on_error_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_q[0]) |-> $past(set));
  assert_flags_fall_on_clear_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(flags_q[1]) |-> $past(clr) || $past(rst));
endmodule

// File: rtl/stspin_pulse.sv
module stspin_pulse #(
  parameter int PULSE_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic cancel,
  output logic hold_low
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (fire)              cnt_d = LOAD;
    else if (cancel)       cnt_d = '0;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  assign hold_low = (cnt_d != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);
  assert_reload_full_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> (cnt_q == LOAD));
endmodule

// File: rtl/stspin_ctrl.sv
module stspin_ctrl
  import stspin_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_PULSE_PS  = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       eng_busy,
  input  logic       eng_susp,
  input  logic       erase_done,
  input  logic       prog_done,
  output logic       sts_pin,
  output logic [1:0] err_flags
);
  localparam int RAW_CYC   = (MIN_PULSE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int PULSE_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  logic cfg_load, err_set, err_clr, fire, hold_low, pulse_mode, sts_q;
  cfg_t cfg_new, cfg_q, cfg_d;

  stspin_cmd_dec u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .eng_busy (eng_busy),
    .eng_susp (eng_susp),
    .cfg_load (cfg_load),
    .cfg_new  (cfg_new),
    .err_set  (err_set),
    .err_clr  (err_clr)
  );

  stspin_err_reg u_err (
    .clk   (clk),
    .rst   (rst),
    .set   (err_set),
    .clr   (err_clr),
    .flags (err_flags)
  );

  // New configuration governs the edge that accepts it
  assign cfg_d      = cfg_load ? cfg_new : cfg_q;
  assign pulse_mode = cfg_d.erase_en | cfg_d.prog_en;
  assign fire       = (erase_done & cfg_d.erase_en) | (prog_done & cfg_d.prog_en);

  stspin_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .cancel   (cfg_load),
    .hold_low (hold_low)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      sts_q <= 1'b1;
    end else begin
      cfg_q <= cfg_d;
      sts_q <= pulse_mode ? ~hold_low : (~eng_busy | eng_susp);
    end
  end

  assign sts_pin = sts_q;

  assert_level_tracks_engine_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cfg_q == '0) |-> (sts_pin == ($past(!eng_busy) || $past(eng_susp))));
  assert_cfg_frozen_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(eng_busy || eng_susp)) |-> $stable(cfg_q));
  assert_pulse_drives_low_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !sts_pin);
  assert_pulse_rests_high_R4: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && !hold_low) |=> sts_pin);
endmodule

// File: tb/stspin_ctrl_tb.sv
module stspin_ctrl_tb;
  localparam int PERIOD_PS = 10000;
  localparam int PULSE = (250000 + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rst = 1'b1, wr_en = 1'b0, busy = 1'b0, susp = 1'b0, er = 1'b0, pr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic sts_pin;
  logic [1:0] err_flags;

  always #5ns clk = ~clk;

  stspin_ctrl #(.CLK_PERIOD_PS(PERIOD_PS), .MIN_PULSE_PS(250000)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .eng_busy(busy), .eng_susp(susp), .erase_done(er), .prog_done(pr),
    .sts_pin(sts_pin), .err_flags(err_flags)
  );

  typedef struct {
    int         cyc;
    logic       sts;
    logic [1:0] err;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int runs = 0;
  int fails = 0;
  bit done = 0;

  // Monitor: pops expectations due in this cycle and compares
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #3ns;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
        exp_t e;
        e = q.pop_front();
        runs++;
        if (e.cyc != cyc || sts_pin !== e.sts || err_flags !== e.err) begin
          fails++;
          $display("FAIL %s cycle %0d: sts=%b err=%b expected sts=%b err=%b",
                   e.tag, cyc, sts_pin, err_flags, e.sts, e.err);
        end
      end
    end
  end

  task automatic cyc_in(input logic b, input logic s, input logic e, input logic p,
                        input logic w, input logic [7:0] d);
    @(negedge clk);
    busy = b; susp = s; er = e; pr = p; wr_en = w; wr_data = d;
  endtask

  task automatic idle();
    cyc_in(0, 0, 0, 0, 0, 8'h00);
  endtask

  task automatic expect_next(input logic s, input logic [1:0] e, input string tag);
    q.push_back('{cyc + 1, s, e, tag});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; busy = 0; susp = 0; er = 0; pr = 0; wr_en = 0; wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // command byte then code, code cycle carries the given side inputs
  task automatic cfg_cmd(input logic [7:0] code, input logic b, input logic s,
                         input logic e, input logic p);
    cyc_in(0, 0, 0, 0, 1, 8'hB8);
    cyc_in(b, s, e, p, 1, code);
  endtask

  // event cycle already driven by caller; checks the whole pulse
  task automatic follow_pulse(input int low_cycles, input logic [1:0] e, input string tag);
    expect_next(1'b0, e, tag);
    for (int k = 1; k < low_cycles; k++) begin
      idle(); expect_next(1'b0, e, tag);
    end
    idle(); expect_next(1'b1, e, tag);
  endtask

  initial begin
    do_reset();
    // R1: reset state
    idle(); expect_next(1'b1, 2'b00, "R1");
    // R2: level mode
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b00, "R2");
    cyc_in(1, 1, 0, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R2");
    cyc_in(0, 1, 0, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R2");
    cyc_in(0, 0, 1, 1, 0, 8'h00); expect_next(1'b1, 2'b00, "R2 events ignored");
    // R10: invalid code
    cfg_cmd(8'h07, 0, 0, 0, 0); expect_next(1'b1, 2'b11, "R10");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b11, "R10 mode kept");
    // R11: clear, other bytes ignored
    cyc_in(0, 0, 0, 0, 1, 8'h50); expect_next(1'b1, 2'b00, "R11");
    cyc_in(0, 0, 0, 0, 1, 8'h13); expect_next(1'b1, 2'b00, "R11 ignored");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b00, "R11 level kept");
    // R9: refused while busy, then while suspended
    cfg_cmd(8'h01, 1, 0, 0, 0); expect_next(1'b0, 2'b11, "R9 busy");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b11, "R9 mode kept");
    cyc_in(0, 0, 0, 0, 1, 8'h50); expect_next(1'b1, 2'b00, "R11");
    cfg_cmd(8'h02, 0, 1, 0, 0); expect_next(1'b1, 2'b11, "R9 susp");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b11, "R9 mode kept");
    cyc_in(0, 0, 0, 0, 1, 8'h50); expect_next(1'b1, 2'b00, "R11");
    // R3/R4: gap between command and code, then erase-only pulse mode
    cyc_in(0, 0, 0, 0, 1, 8'hB8);
    idle(); idle();
    cyc_in(0, 0, 0, 0, 1, 8'h01); expect_next(1'b1, 2'b00, "R3");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R4 busy ignored");
    cyc_in(0, 0, 0, 1, 0, 8'h00); expect_next(1'b1, 2'b00, "R4 prog ignored");
    cyc_in(0, 0, 1, 0, 0, 8'h00); follow_pulse(PULSE, 2'b00, "R7 erase pulse");
    // R5: program-only
    cfg_cmd(8'h02, 0, 0, 0, 0); expect_next(1'b1, 2'b00, "R5");
    cyc_in(0, 0, 1, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R5 erase ignored");
    cyc_in(0, 0, 0, 1, 0, 8'h00); follow_pulse(PULSE, 2'b00, "R5 prog pulse");
    // R6: both enabled, simultaneous events give one pulse
    cfg_cmd(8'h03, 0, 0, 0, 0); expect_next(1'b1, 2'b00, "R6");
    cyc_in(0, 0, 1, 1, 0, 8'h00); follow_pulse(PULSE, 2'b00, "R6 joint pulse");
    // R7: restart during a pulse
    cyc_in(0, 0, 1, 0, 0, 8'h00); expect_next(1'b0, 2'b00, "R7 restart");
    for (int k = 1; k < 10; k++) begin
      idle(); expect_next(1'b0, 2'b00, "R7 restart");
    end
    cyc_in(0, 0, 0, 1, 0, 8'h00); follow_pulse(PULSE, 2'b00, "R7 restart");
    // R12: code write and event together
    cfg_cmd(8'h00, 0, 0, 1, 1); expect_next(1'b1, 2'b00, "R12 to level");
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b00, "R3 level again");
    cfg_cmd(8'h01, 0, 0, 1, 0); follow_pulse(PULSE, 2'b00, "R12 to erase");
    // R8: held across busy cycles, cleared by reset
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R8 held");
    cfg_cmd(8'h09, 0, 0, 0, 0); expect_next(1'b1, 2'b11, "R10");
    cyc_in(0, 0, 1, 0, 0, 8'h00); follow_pulse(PULSE, 2'b11, "R8 still erase");
    do_reset();
    cyc_in(1, 0, 0, 0, 0, 8'h00); expect_next(1'b0, 2'b00, "R8 reset to level");
    cyc_in(0, 0, 1, 0, 0, 8'h00); expect_next(1'b1, 2'b00, "R1 after reset");
    repeat (4) idle();
    if (q.size() != 0) begin
      fails++;
      $display("FAIL queue: %0d expectations left, expected 0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule